// File: doc/BRIEF.md
# Pattern and Edge Trigger Unit

This block decides when a logic-analyzer capture starts. Sixteen input channels arrive as one word. A sample strobe marks the clock cycles in which that word is a real sample. Each sampled word is tested against two conditions. The first is a per-channel level pattern, where each channel is required high, required low, or ignored. The second is a rising or falling transition on a chosen channel, found by comparing the word with the previous sampled word. A second transition condition on another channel may be added. It counts only when both transitions show up between the same pair of consecutive samples.

Two reduced-width rate modes keep only the lower 8 or the lower 4 channels. In these modes the level pattern and the second transition are not used. The only trigger left is the first transition, and its channel must lie inside the reduced width. Software arms the unit with a one-cycle command. On the first qualifying sample the unit pulses its trigger output for one cycle and latches a triggered flag. It then ignores the inputs until it is armed again.

Top module: `pattern_edge_trigger`

## Requirements
- R1: After reset, `trigPulse` and `triggered` are 0 and the unit is unarmed. An unarmed unit never pulses, even when the inputs satisfy every condition.
- R2: In full mode (`rateMode` 0 or 3), a channel whose `patCare` bit is 1 must equal its `patValue` bit. A channel whose `patCare` bit is 0 never blocks a match.
- R3: With `edgeAEn`=1, the channel `edgeACh` must go 0 to 1 (`edgeARise`=1) or 1 to 0 (`edgeARise`=0) between the previous sampled word and the current sampled word. In full mode the trigger needs this transition and the pattern in the same sample.
- R4: In full mode with `edgeAEn`=0 and `edgeBEn`=0, the trigger is a pure pattern match.
- R5: In full mode with `edgeBEn`=1, channel `edgeBCh` must also make its programmed transition (`edgeBRise` coded like `edgeARise`) in the same sample as the other conditions.
- R6: With `rateMode`=1 (8 channels) or `rateMode`=2 (4 channels), the pattern and condition B have no effect. A trigger needs `edgeAEn`=1, `edgeACh` below 8 or 4 respectively, and the condition-A transition. Otherwise the unit never fires.
- R7: The first sample after arming only loads the previous-sample word. It can never produce a transition match.
- R8: A hit on a sample taken in cycle N gives `trigPulse`=1 in cycle N+1 only, and sets `triggered` from cycle N+1. After that, samples have no effect until the next `arm`.
- R9: A cycle with `sampleEn`=0 neither triggers nor updates the previous-sample word.
- R10: `arm` clears `triggered` in the next cycle. A sample strobe in the same cycle as `arm` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| arm | input | 1 | One-cycle arm command; clears the triggered flag |
| sampleEn | input | 1 | Marks a cycle whose input word is a sample |
| sampleIn | input | 16 | Channel input word |
| rateMode | input | 2 | 0/3 full width, 1 eight channels, 2 four channels |
| patValue | input | 16 | Required level per channel |
| patCare | input | 16 | 1 = compare this channel, 0 = ignore |
| edgeAEn | input | 1 | Enable transition condition A |
| edgeACh | input | 4 | Channel of condition A |
| edgeARise | input | 1 | 1 rising, 0 falling for condition A |
| edgeBEn | input | 1 | Enable transition condition B (full mode) |
| edgeBCh | input | 4 | Channel of condition B |
| edgeBRise | input | 1 | 1 rising, 0 falling for condition B |
| trigPulse | output | 1 | One-cycle trigger pulse |
| triggered | output | 1 | Latched trigger status |

## Verification
Every result comes from a single register stage. A sample presented with the strobe in cycle N shows its `trigPulse` in cycle N+1. An `arm` given in cycle N shows up as a cleared `triggered` in cycle N+1. The bench drives inputs on the falling edge and first computes the expected hit from its own model state. It then waits for the next rising edge and checks both outputs one nanosecond after it, so each check sees exactly the register update belonging to that stimulus. The bench updates its previous-sample model only on strobed, armed, non-arm cycles, which also checks R9 and R10.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic [1:0] {
    RATE_FULL    = 2'd0,
    RATE_HALF    = 2'd1,
    RATE_QUARTER = 2'd2,
    RATE_FULL2   = 2'd3
  } rateMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPrev;
    logic clearPrev;
  } trigStrobe_t;

endpackage

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int CH_W       = 16,
  parameter int HALF_CH    = 8,
  parameter int QUARTER_CH = 4,
  localparam int IDX_W     = $clog2(CH_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  trigStrobe_t       strobe,
  input  logic [CH_W-1:0]   sampleIn,
  input  logic [1:0]        rateMode,
  input  logic [CH_W-1:0]   patValue,
  input  logic [CH_W-1:0]   patCare,
  input  logic              edgeAEn,
  input  logic [IDX_W-1:0]  edgeACh,
  input  logic              edgeARise,
  input  logic              edgeBEn,
  input  logic [IDX_W-1:0]  edgeBCh,
  input  logic              edgeBRise,
  output logic              match
);

  logic [CH_W-1:0] prevWord;
  logic            prevValid;
  logic [CH_W-1:0] riseVec;
  logic [CH_W-1:0] fallVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevWord  <= '0;
      prevValid <= 1'b0;
    end else if (strobe.clearPrev) begin
      prevValid <= 1'b0;
    end else if (strobe.loadPrev) begin
      prevWord  <= sampleIn;
      prevValid <= 1'b1;
    end
  end

  for (genvar i = 0; i < CH_W; i++) begin : g_edge
    assign riseVec[i] = sampleIn[i] & ~prevWord[i];
    assign fallVec[i] = ~sampleIn[i] & prevWord[i];
  end

  logic patOk;
  logic edgeAHit;
  logic edgeBHit;
  logic fullMode;
  logic chInRange;

  always_comb begin
    patOk    = ((sampleIn ^ patValue) & patCare) == '0;
    edgeAHit = prevValid && (edgeARise ? riseVec[edgeACh] : fallVec[edgeACh]);
    edgeBHit = prevValid && (edgeBRise ? riseVec[edgeBCh] : fallVec[edgeBCh]);
    unique case (rateMode_e'(rateMode))
      RATE_HALF: begin
        fullMode  = 1'b0;
        chInRange = int'(edgeACh) < HALF_CH;
      end
      RATE_QUARTER: begin
        fullMode  = 1'b0;
        chInRange = int'(edgeACh) < QUARTER_CH;
      end
      default: begin
        fullMode  = 1'b1;
        chInRange = 1'b1;
      end
    endcase
    if (fullMode)
      match = patOk && (!edgeAEn || edgeAHit) && (!edgeBEn || edgeBHit);
    else
      match = edgeAEn && chInRange && edgeAHit;
  end

endmodule

// File: rtl/trig_control.sv
module trig_control
  import trig_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        arm,
  input  logic        sampleEn,
  input  logic        match,
  output trigStrobe_t strobe,
  output logic        trigPulse,
  output logic        triggered
);

  logic armed;
  logic hit;

  always_comb begin
    strobe.clearPrev = arm;
    strobe.loadPrev  = armed & sampleEn & ~arm;
    hit              = strobe.loadPrev & match;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed     <= 1'b0;
      triggered <= 1'b0;
      trigPulse <= 1'b0;
    end else begin
      trigPulse <= hit;
      if (arm) begin
        armed     <= 1'b1;
        triggered <= 1'b0;
      end else if (hit) begin
        armed     <= 1'b0;
        triggered <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pattern_edge_trigger.sv
module pattern_edge_trigger
  import trig_pkg::*;
#(
  parameter int CH_W       = 16,
  parameter int HALF_CH    = 8,
  parameter int QUARTER_CH = 4,
  localparam int IDX_W     = $clog2(CH_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             arm,
  input  logic             sampleEn,
  input  logic [CH_W-1:0]  sampleIn,
  input  logic [1:0]       rateMode,
  input  logic [CH_W-1:0]  patValue,
  input  logic [CH_W-1:0]  patCare,
  input  logic             edgeAEn,
  input  logic [IDX_W-1:0] edgeACh,
  input  logic             edgeARise,
  input  logic             edgeBEn,
  input  logic [IDX_W-1:0] edgeBCh,
  input  logic             edgeBRise,
  output logic             trigPulse,
  output logic             triggered
);

  trigStrobe_t strobe;
  logic        match;

  trig_control u_ctrl (
    .clk(clk), .rstN(rstN), .arm(arm), .sampleEn(sampleEn), .match(match),
    .strobe(strobe), .trigPulse(trigPulse), .triggered(triggered)
  );

  trig_datapath #(
    .CH_W(CH_W), .HALF_CH(HALF_CH), .QUARTER_CH(QUARTER_CH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleIn(sampleIn),
    .rateMode(rateMode), .patValue(patValue), .patCare(patCare),
    .edgeAEn(edgeAEn), .edgeACh(edgeACh), .edgeARise(edgeARise),
    .edgeBEn(edgeBEn), .edgeBCh(edgeBCh), .edgeBRise(edgeBRise),
    .match(match)
  );

endmodule

// File: rtl/trig_checks.sv
module trig_checks #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             arm,
  input logic             sampleEn,
  input logic [1:0]       rateMode,
  input logic             edgeAEn,
  input logic [IDX_W-1:0] edgeACh,
  input logic             trigPulse,
  input logic             triggered
);

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |=> !trigPulse);

  // R8
  pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> triggered);

  // R8
  flag_latched_chk: assert property (@(posedge clk) disable iff (!rstN)
    (triggered && !arm) |=> triggered);

  // R9
  pulse_needs_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trigPulse) |-> $past(sampleEn) && !$past(arm));

  // R10
  arm_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    arm |=> !triggered && !trigPulse);

  // R6
  quarter_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigPulse && $past(rateMode) == 2'd2) |-> ($past(edgeAEn) && $past(edgeACh) < 4));

  // R6
  half_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigPulse && $past(rateMode) == 2'd1) |-> ($past(edgeAEn) && $past(edgeACh) < 8));

endmodule

bind pattern_edge_trigger trig_checks #(.IDX_W(IDX_W)) u_checks (
  .clk(clk), .rstN(rstN), .arm(arm), .sampleEn(sampleEn), .rateMode(rateMode),
  .edgeAEn(edgeAEn), .edgeACh(edgeACh), .trigPulse(trigPulse), .triggered(triggered)
);

// File: tb/tb_pattern_edge_trigger.sv
module tb_pattern_edge_trigger;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        arm = 1'b0;
  logic        sampleEn = 1'b0;
  logic [15:0] sampleIn = '0;
  logic [1:0]  rateMode = 2'd0;
  logic [15:0] patValue = '0;
  logic [15:0] patCare = '0;
  logic        edgeAEn = 1'b0;
  logic [3:0]  edgeACh = '0;
  logic        edgeARise = 1'b1;
  logic        edgeBEn = 1'b0;
  logic [3:0]  edgeBCh = '0;
  logic        edgeBRise = 1'b1;
  logic        trigPulse;
  logic        triggered;

  int checkCount = 0;
  int failCount = 0;

  // bench model state
  bit        mArmed = 0;
  bit        mTrig = 0;
  bit        mPrevValid = 0;
  bit [15:0] mPrev = '0;

  always #4 clk = ~clk;

  pattern_edge_trigger dut (
    .clk(clk), .rstN(rstN), .arm(arm), .sampleEn(sampleEn), .sampleIn(sampleIn),
    .rateMode(rateMode), .patValue(patValue), .patCare(patCare),
    .edgeAEn(edgeAEn), .edgeACh(edgeACh), .edgeARise(edgeARise),
    .edgeBEn(edgeBEn), .edgeBCh(edgeBCh), .edgeBRise(edgeBRise),
    .trigPulse(trigPulse), .triggered(triggered)
  );

  function automatic bit chanEdge(bit [15:0] cur, bit [15:0] prv, int ch, bit rise);
    return rise ? (cur[ch] && !prv[ch]) : (!cur[ch] && prv[ch]);
  endfunction

  function automatic bit expMatch(bit [15:0] cur);
    bit a, b, p;
    a = mPrevValid && chanEdge(cur, mPrev, int'(edgeACh), edgeARise);
    b = mPrevValid && chanEdge(cur, mPrev, int'(edgeBCh), edgeBRise);
    p = ((cur ^ patValue) & patCare) == 16'h0;
    if (rateMode == 2'd1) return edgeAEn && edgeACh < 8 && a;
    if (rateMode == 2'd2) return edgeAEn && edgeACh < 4 && a;
    return p && (!edgeAEn || a) && (!edgeBEn || b);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit doArm, bit en, bit [15:0] data, string tag);
    bit expHit;
    @(negedge clk);
    arm = doArm;
    sampleEn = en;
    sampleIn = data;
    expHit = !doArm && en && mArmed && expMatch(data);
    @(posedge clk);
    #1;
    if (doArm) begin
      mArmed = 1; mTrig = 0; mPrevValid = 0;
    end else if (mArmed && en) begin
      if (expHit) begin mArmed = 0; mTrig = 1; end
      mPrev = data; mPrevValid = 1;
    end
    check(tag, "trigPulse", int'(trigPulse), int'(expHit));
    check(tag, "triggered", int'(triggered), int'(mTrig));
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    check("R1", "trigPulse after reset", int'(trigPulse), 0);
    check("R1", "triggered after reset", int'(triggered), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R1: unarmed, everything matches
    step(0, 1, 16'h1234, "R1");
    step(0, 1, 16'h0000, "R1");

    // R7 / R3: rising on ch0; first sample after arm cannot match
    edgeAEn = 1; edgeACh = 0; edgeARise = 1;
    step(1, 0, 16'h0000, "R10");
    step(0, 1, 16'h0001, "R7");
    step(0, 1, 16'h0000, "R3");
    step(0, 1, 16'h0001, "R3");
    // R8: further matches ignored while latched
    step(0, 1, 16'h0000, "R8");
    step(0, 1, 16'h0001, "R8");

    // R10: arm with a strobe in the same cycle
    step(1, 1, 16'h0000, "R10");
    step(0, 1, 16'h0000, "R10");
    // R9: change without strobe, then strobe sees edge against old prev
    step(0, 0, 16'h0001, "R9");
    step(0, 1, 16'h0001, "R9");

    // R2 / R4: pure pattern, ch3 must be 1 and ch15 0, rest ignored
    edgeAEn = 0; patCare = 16'h8008; patValue = 16'h0008;
    step(1, 0, 16'h0, "R4");
    step(0, 1, 16'h8008, "R2");
    step(0, 1, 16'h7FF7, "R2");
    step(0, 1, 16'h7FFF, "R4");

    // R3 falling with pattern; R5 second edge
    patCare = 16'h0100; patValue = 16'h0100;
    edgeAEn = 1; edgeACh = 4'd2; edgeARise = 0;
    edgeBEn = 1; edgeBCh = 4'd9; edgeBRise = 1;
    step(1, 0, 16'h0, "R5");
    step(0, 1, 16'h0104, "R5");
    step(0, 1, 16'h0100, "R5");
    step(0, 1, 16'h0104, "R5");
    step(0, 1, 16'h0300, "R5");

    // R6: four-channel mode, channel out of range never fires
    edgeBEn = 0; rateMode = 2'd2; edgeACh = 4'd5; edgeARise = 1;
    step(1, 0, 16'h0, "R6");
    step(0, 1, 16'h0000, "R6");
    step(0, 1, 16'h0020, "R6");
    edgeACh = 4'd3;
    step(0, 1, 16'h0000, "R6");
    step(0, 1, 16'h0008, "R6");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit [15:0] d;
      if (i % 50 == 0) begin
        rateMode  = 2'($urandom);
        patCare   = 16'($urandom & $urandom & $urandom);
        patValue  = 16'($urandom);
        edgeAEn   = 1'($urandom);
        edgeACh   = 4'($urandom);
        edgeARise = 1'($urandom);
        edgeBEn   = ($urandom % 4) == 0;
        edgeBCh   = 4'($urandom);
        edgeBRise = 1'($urandom);
      end
      d = sampleIn ^ 16'($urandom & $urandom);
      step(($urandom % 12) == 0, ($urandom % 4) != 0, d, "R3");
    end

    summary();
  end

endmodule